// File: doc/BRIEF.md
# CPU Card Address Decoder with Clock Stretching

This block is the glue logic of a 6502-style CPU card. It maps each bus cycle to one of four regions: the lower RAM bank, the upper RAM bank, a small boot ROM, or a peripheral window. It drives the chip selects and the shared RAM strobes for that region. It also makes the CPU clock (PHI2) from a free-running input clock.

Slow devices are served by holding PHI2 high for a fixed number of extra input-clock periods, so the CPU never needs its ready line. RAM bank 0 is selected by A15 low and RAM bank 1 by A15 high, with no further decoding, so the RAM selects settle as early as possible. When a cycle falls in the ROM or peripheral space, the decode instead withholds the RAM output-enable and write-enable.

The stretch decision and all RAM-side signals depend only on A15..A9. The split between ROM and the peripheral window inside the top 512 bytes also uses A8..A6.

Top module: `bus_glue_stretch`

## Requirements
- R1: `ram0_cs_n` is low exactly when A15 (`addr_hi[6]`) is 0.
- R2: `ram1_cs_n` is low exactly when A15 is 1, whatever the other address bits are, including the ROM and peripheral space.
- R3: The slow space is A15..A9 all ones ($FE00-$FFFF). Inside it, `io_cs_n` is low when A8=1 and {A7,A6} is not 2'b11 ($FF00-$FFBF); otherwise `rom_cs_n` is low. `addr_mid` carries {A8,A7,A6} in bits [2:0]. Outside the slow space both selects are high.
- R4: In the slow space, `ram_oe_n` and `ram_we_n` are both high whatever `rw` and `phi2` are.
- R5: Outside the slow space, `ram_oe_n` is low exactly when `rw`=1 (read).
- R6: Outside the slow space, `ram_we_n` is low exactly when `rw`=0 (write) and `phi2` is high.
- R7: A cycle outside the slow space keeps `phi2` high for exactly one input-clock period. Every low phase of `phi2` lasts exactly one period.
- R8: A cycle in the slow space keeps `phi2` high for 1+STRETCH_CLKS input-clock periods (4 with the default of 3).
- R9: While `rst_n` is low, `phi2` is low and the stretch count is cleared. A reset during a stretch ends it at once. After release, `phi2` toggles normally.
- R10: The stretch length is fixed by the address seen on the clock edge where `phi2` rises. Address changes during the high phase do not shorten or lengthen it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Free-running input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hi | input | 7 | CPU address bits A15..A9 (bit 6 = A15) |
| addr_mid | input | 3 | CPU address bits A8..A6 (bit 2 = A8) |
| rw | input | 1 | CPU read/write line, 1 = read |
| phi2 | output | 1 | Stretched CPU clock |
| ram0_cs_n | output | 1 | Lower RAM bank select, active low |
| ram1_cs_n | output | 1 | Upper RAM bank select, active low |
| ram_oe_n | output | 1 | Shared RAM output enable, active low |
| ram_we_n | output | 1 | Shared RAM write enable, active low |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| io_cs_n | output | 1 | Peripheral window select, active low |

## Verification
The bench probes the boundary addresses $7FFF/$8000, $FDFF/$FE00, $FEFF/$FF00 and $FFBF/$FFC0. A decoder that is off by one bit at any of these would give the cycle the wrong select, or would stretch RAM while leaving ROM fast. It measures high and low phase lengths in input-clock periods for RAM, ROM and peripheral cycles. An off-by-one reload of the stretch counter shows up there as a phase of 3 or 5 periods instead of 4. It changes the address in the middle of a high phase to catch a design that re-decodes instead of latching the decision. It asserts reset during a stretch to catch a counter that is left loaded. It also checks that a RAM write strobe never appears during the low phase or in the slow space, which would corrupt upper-bank RAM that is selected there.

// File: rtl/glue_pkg.sv
package glue_pkg;
   localparam int UPPER_W = 7;   // A15..A9
   localparam int MID_W   = 3;   // A8..A6

   typedef enum logic [1:0] {
      RG_RAM0 = 2'd0,
      RG_RAM1 = 2'd1,
      RG_ROM  = 2'd2,
      RG_IO   = 2'd3
   } region_t;

   function automatic logic is_slow(region_t r);
      return (r == RG_ROM) || (r == RG_IO);
   endfunction
endpackage

// File: rtl/glue_region_decode.sv
module glue_region_decode
   import glue_pkg::*;
#(
   parameter logic [UPPER_W-1:0] SLOW_PAT = 7'h7F,
   parameter bit                 IO_EN    = 1'b1,
   parameter logic [1:0]         IO_EXCL  = 2'b11
) (
   input  logic [UPPER_W-1:0] addr_hi,
   input  logic [MID_W-1:0]   addr_mid,
   output region_t            region,
   output logic               slow
);
   localparam int TOP = UPPER_W - 1;

   logic in_slow_space;
   logic io_hit;

   assign in_slow_space = (addr_hi == SLOW_PAT);

   generate
      if (IO_EN) begin : g_io
         // window: A8 set and A7..A6 not the excluded pattern
         assign io_hit = addr_mid[2] & (addr_mid[1:0] != IO_EXCL);
      end else begin : g_no_io
         logic unused_mid;
         assign unused_mid = ^addr_mid;
         assign io_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!addr_hi[TOP])      region = RG_RAM0;
      else if (!in_slow_space) region = RG_RAM1;
      else if (io_hit)        region = RG_IO;
      else                    region = RG_ROM;
   end

   assign slow = is_slow(region);
endmodule

// File: rtl/glue_phi_stretch.sv
module glue_phi_stretch #(
   parameter int STRETCH_CLKS = 3
) (
   input  logic clk_in,
   input  logic rst_n,
   input  logic slow,
   output logic phi2
);
   generate
      if (STRETCH_CLKS == 0) begin : g_plain
         logic unused_slow;
         assign unused_slow = slow;
         always_ff @(posedge clk_in or negedge rst_n) begin
            if (!rst_n) phi2 <= 1'b0;
            else        phi2 <= ~phi2;
         end
      end else begin : g_count
         localparam int CW = (STRETCH_CLKS < 2) ? 1 : $clog2(STRETCH_CLKS + 1);
         logic [CW-1:0] remain;

         always_ff @(posedge clk_in or negedge rst_n) begin
            if (!rst_n) begin
               phi2   <= 1'b0;
               remain <= '0;
            end else if (!phi2) begin
               phi2   <= 1'b1;
               remain <= slow ? CW'(STRETCH_CLKS) : '0;
            end else if (remain != '0) begin
               remain <= remain - 1'b1;
            end else begin
               phi2 <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/glue_strobe_gate.sv
module glue_strobe_gate
   import glue_pkg::*;
(
   input  glue_pkg::region_t region,
   input  logic              rw,
   input  logic              phi2,
   output logic              ram_oe_n,
   output logic              ram_we_n,
   output logic              rom_cs_n,
   output logic              io_cs_n
);
   logic ram_space;

   assign ram_space = (region == RG_RAM0) || (region == RG_RAM1);
   assign ram_oe_n  = ~(ram_space & rw);
   assign ram_we_n  = ~(ram_space & ~rw & phi2);
   assign rom_cs_n  = ~(region == RG_ROM);
   assign io_cs_n   = ~(region == RG_IO);
endmodule

// File: rtl/bus_glue_stretch.sv
module bus_glue_stretch
   import glue_pkg::*;
#(
   parameter int                 STRETCH_CLKS = 3,
   parameter logic [UPPER_W-1:0] SLOW_PAT     = 7'h7F,
   parameter bit                 IO_EN        = 1'b1,
   parameter logic [1:0]         IO_EXCL      = 2'b11
) (
   input  logic               clk_in,
   input  logic               rst_n,
   input  logic [UPPER_W-1:0] addr_hi,
   input  logic [MID_W-1:0]   addr_mid,
   input  logic               rw,
   output logic               phi2,
   output logic               ram0_cs_n,
   output logic               ram1_cs_n,
   output logic               ram_oe_n,
   output logic               ram_we_n,
   output logic               rom_cs_n,
   output logic               io_cs_n
);
   localparam int A15 = UPPER_W - 1;

   generate
      if (STRETCH_CLKS < 0 || STRETCH_CLKS > 255) begin : g_bad_stretch
         $error("STRETCH_CLKS must lie in 0..255");
      end
      if (SLOW_PAT[A15] != 1'b1) begin : g_bad_pat
         $error("SLOW_PAT must lie in the upper half");
      end
   endgenerate

   region_t region;
   logic    slow;

   // RAM selects use the top bit alone
   assign ram0_cs_n = addr_hi[A15];
   assign ram1_cs_n = ~addr_hi[A15];

   glue_region_decode #(
      .SLOW_PAT (SLOW_PAT),
      .IO_EN    (IO_EN),
      .IO_EXCL  (IO_EXCL)
   ) u_decode (
      .addr_hi  (addr_hi),
      .addr_mid (addr_mid),
      .region   (region),
      .slow     (slow)
   );

   glue_phi_stretch #(
      .STRETCH_CLKS (STRETCH_CLKS)
   ) u_stretch (
      .clk_in (clk_in),
      .rst_n  (rst_n),
      .slow   (slow),
      .phi2   (phi2)
   );

   glue_strobe_gate u_gate (
      .region   (region),
      .rw       (rw),
      .phi2     (phi2),
      .ram_oe_n (ram_oe_n),
      .ram_we_n (ram_we_n),
      .rom_cs_n (rom_cs_n),
      .io_cs_n  (io_cs_n)
   );
endmodule

// File: rtl/glue_checker.sv
module glue_checker #(
   parameter int STRETCH_CLKS = 3
) (
   input logic       clk_in,
   input logic       rst_n,
   input logic [6:0] addr_hi,
   input logic       rw,
   input logic       phi2,
   input logic       ram0_cs_n,
   input logic       ram1_cs_n,
   input logic       ram_oe_n,
   input logic       ram_we_n,
   input logic       rom_cs_n,
   input logic       io_cs_n
);
   logic       slow_now;
   logic       slow_at_rise;
   logic [8:0] hi_len;

   assign slow_now = !rom_cs_n || !io_cs_n;

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         hi_len       <= '0;
         slow_at_rise <= 1'b0;
      end else if (!phi2) begin
         hi_len       <= '0;
         slow_at_rise <= slow_now;
      end else begin
         hi_len <= hi_len + 1'b1;
      end
   end

   a_r1_lower_bank: assert property (@(posedge clk_in) disable iff (!rst_n)
      !addr_hi[6] |-> (!ram0_cs_n && ram1_cs_n));

   a_r2_upper_bank: assert property (@(posedge clk_in) disable iff (!rst_n)
      addr_hi[6] |-> (ram0_cs_n && !ram1_cs_n));

   a_r3_one_slow_select: assert property (@(posedge clk_in) disable iff (!rst_n)
      !(!rom_cs_n && !io_cs_n));

   a_r4_ram_quiet_slow: assert property (@(posedge clk_in) disable iff (!rst_n)
      slow_now |-> (ram_oe_n && ram_we_n));

   a_r6_write_in_high: assert property (@(posedge clk_in) disable iff (!rst_n)
      !ram_we_n |-> (phi2 && !rw));

   a_r7_low_one_clk: assert property (@(posedge clk_in) disable iff (!rst_n)
      $fell(phi2) |=> phi2);

   a_r8_high_length: assert property (@(posedge clk_in) disable iff (!rst_n)
      $fell(phi2) |-> (hi_len == (slow_at_rise ? 9'(STRETCH_CLKS + 1) : 9'd1)));
endmodule

bind bus_glue_stretch glue_checker #(.STRETCH_CLKS(STRETCH_CLKS)) u_glue_chk (
   .clk_in    (clk_in),
   .rst_n     (rst_n),
   .addr_hi   (addr_hi),
   .rw        (rw),
   .phi2      (phi2),
   .ram0_cs_n (ram0_cs_n),
   .ram1_cs_n (ram1_cs_n),
   .ram_oe_n  (ram_oe_n),
   .ram_we_n  (ram_we_n),
   .rom_cs_n  (rom_cs_n),
   .io_cs_n   (io_cs_n)
);

// File: tb/bus_glue_stretch_test.sv
module bus_glue_stretch_test;
   localparam int CLK_PERIOD = 10;
   localparam int STRETCH    = 3;

   logic        clk_in = 1'b0;
   logic        rst_n  = 1'b0;
   logic [15:0] a      = 16'h0000;
   logic        rw     = 1'b1;
   logic phi2, ram0_cs_n, ram1_cs_n, ram_oe_n, ram_we_n, rom_cs_n, io_cs_n;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk_in = ~clk_in;

   bus_glue_stretch #(.STRETCH_CLKS(STRETCH)) uut (
      .clk_in    (clk_in),
      .rst_n     (rst_n),
      .addr_hi   (a[15:9]),
      .addr_mid  (a[8:6]),
      .rw        (rw),
      .phi2      (phi2),
      .ram0_cs_n (ram0_cs_n),
      .ram1_cs_n (ram1_cs_n),
      .ram_oe_n  (ram_oe_n),
      .ram_we_n  (ram_we_n),
      .rom_cs_n  (rom_cs_n),
      .io_cs_n   (io_cs_n)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // expected selects from the requirements: {ram0,ram1,oe,we,rom,io}
   function automatic logic [5:0] expect_bus(input logic [15:0] ad, input logic r,
                                             input logic p);
      logic slow, io;
      slow = (ad[15:9] == 7'h7F);
      io   = slow && ad[8] && (ad[7:6] != 2'b11);
      return {ad[15], ~ad[15],
              ~(!slow && r), ~(!slow && !r && p),
              ~(slow && !io), ~io};
   endfunction

   task automatic check_decode(input logic [15:0] ad, input logic r);
      logic [5:0] act, exp;
      @(negedge clk_in);
      a = ad; rw = r;
      #1;
      act = {ram0_cs_n, ram1_cs_n, ram_oe_n, ram_we_n, rom_cs_n, io_cs_n};
      exp = expect_bus(ad, r, phi2);
      check(act[5] == exp[5], "R1", $sformatf("ram0_cs_n @%h", ad), act[5], exp[5]);
      check(act[4] == exp[4], "R2", $sformatf("ram1_cs_n @%h", ad), act[4], exp[4]);
      check(act[1:0] == exp[1:0], "R3", $sformatf("rom/io @%h", ad), act[1:0], exp[1:0]);
      check(act[3] == exp[3], (ad[15:9] == 7'h7F) ? "R4" : "R5",
            $sformatf("ram_oe_n @%h rw=%0d", ad, r), act[3], exp[3]);
      check(act[2] == exp[2], (ad[15:9] == 7'h7F) ? "R4" : "R6",
            $sformatf("ram_we_n @%h rw=%0d", ad, r), act[2], exp[2]);
   endtask

   // start a cycle at ad, optionally switch address after first high period,
   // return high-phase length and following low-phase length
   task automatic run_cycle(input logic [15:0] ad, input logic r,
                            input bit do_sw, input logic [15:0] ad_sw,
                            output int hi, output int lo);
      do @(negedge clk_in); while (phi2 !== 1'b0);
      a = ad; rw = r;
      hi = 0; lo = 0;
      @(negedge clk_in);
      while (phi2 === 1'b1 && hi < 1000) begin
         hi++;
         if (do_sw && hi == 1) a = ad_sw;
         @(negedge clk_in);
      end
      while (phi2 === 1'b0 && lo < 1000) begin
         lo++;
         @(negedge clk_in);
      end
   endtask

   task automatic t_reset_state();
      repeat (3) @(negedge clk_in);
      check(phi2 == 1'b0, "R9", "phi2 in reset", phi2, 0);
      @(negedge clk_in);
      rst_n = 1'b1;
      @(negedge clk_in);
      check(phi2 == 1'b1, "R9", "phi2 rises after release", phi2, 1);
   endtask

   task automatic t_decode_map();
      check_decode(16'h0000, 1'b1);
      check_decode(16'h7FFF, 1'b0);
      check_decode(16'h8000, 1'b1);
      check_decode(16'hFDFF, 1'b0);
      check_decode(16'hFE00, 1'b1);
      check_decode(16'hFEFF, 1'b0);
      check_decode(16'hFF00, 1'b1);
      check_decode(16'hFF40, 1'b0);
      check_decode(16'hFFBF, 1'b1);
      check_decode(16'hFFC0, 1'b0);
      check_decode(16'hFFFF, 1'b1);
   endtask

   task automatic t_fast_cycles();
      int hi, lo;
      run_cycle(16'h1234, 1'b1, 0, 16'h0, hi, lo);
      check(hi == 1, "R7", "bank0 read high", hi, 1);
      check(lo == 1, "R7", "low phase", lo, 1);
      run_cycle(16'hC000, 1'b0, 0, 16'h0, hi, lo);
      check(hi == 1, "R7", "bank1 write high", hi, 1);
      run_cycle(16'hFDFF, 1'b1, 0, 16'h0, hi, lo);
      check(hi == 1, "R7", "top of bank1 high", hi, 1);
   endtask

   task automatic t_slow_cycles();
      int hi, lo;
      run_cycle(16'hFE10, 1'b1, 0, 16'h0, hi, lo);
      check(hi == STRETCH + 1, "R8", "rom high", hi, STRETCH + 1);
      check(lo == 1, "R7", "low after rom", lo, 1);
      run_cycle(16'hFF20, 1'b0, 0, 16'h0, hi, lo);
      check(hi == STRETCH + 1, "R8", "io high", hi, STRETCH + 1);
      run_cycle(16'hFFFC, 1'b1, 0, 16'h0, hi, lo);
      check(hi == STRETCH + 1, "R8", "vector rom high", hi, STRETCH + 1);
   endtask

   task automatic t_write_window();
      do @(negedge clk_in); while (phi2 !== 1'b0);
      a = 16'h2000; rw = 1'b0;
      #1;
      check(ram_we_n == 1'b1, "R6", "we_n in low phase", ram_we_n, 1);
      @(negedge clk_in);
      check(ram_we_n == 1'b0, "R6", "we_n in high phase", ram_we_n, 0);
      check(ram_oe_n == 1'b1, "R5", "oe_n on write", ram_oe_n, 1);
      do @(negedge clk_in); while (phi2 !== 1'b0);
      a = 16'hFF10; rw = 1'b0;
      @(negedge clk_in);
      check(ram_we_n == 1'b1, "R4", "we_n high in io write", ram_we_n, 1);
      check(ram1_cs_n == 1'b0, "R2", "bank1 selected in io", ram1_cs_n, 0);
   endtask

   task automatic t_latch_decision();
      int hi, lo;
      run_cycle(16'hFE80, 1'b1, 1, 16'h0100, hi, lo);
      check(hi == STRETCH + 1, "R10", "rom then ram addr", hi, STRETCH + 1);
      run_cycle(16'h4000, 1'b1, 1, 16'hFF00, hi, lo);
      check(hi == 1, "R10", "ram then io addr", hi, 1);
   endtask

   task automatic t_reset_midstretch();
      int hi, lo;
      do @(negedge clk_in); while (phi2 !== 1'b0);
      a = 16'hFE00; rw = 1'b1;
      repeat (2) @(negedge clk_in);
      check(phi2 == 1'b1, "R8", "still stretched", phi2, 1);
      rst_n = 1'b0;
      #1;
      check(phi2 == 1'b0, "R9", "phi2 drops on reset", phi2, 0);
      a = 16'h0040;
      repeat (2) @(negedge clk_in);
      check(phi2 == 1'b0, "R9", "phi2 held in reset", phi2, 0);
      rst_n = 1'b1;
      run_cycle(16'h0040, 1'b1, 0, 16'h0, hi, lo);
      check(hi == 1, "R9", "no leftover stretch", hi, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      t_reset_state();
      t_decode_map();
      t_fast_cycles();
      t_slow_cycles();
      t_write_window();
      t_latch_decision();
      t_reset_midstretch();
      repeat (4) @(negedge clk_in);
      summary();
   end
endmodule